// File: doc/BRIEF.md
# TDM Slave Serial Audio Port

This block is the serial side of a multichannel audio codec. It runs as a slave: an external bit clock and frame sync come in, and the block generates neither. Each frame carries eight 32-bit time slots, so the bit clock runs at 256 times the frame rate. Six playback words are received from the serial input. Four capture words are sent on the serial output. Samples sit left justified in their slot, and the valid length is selectable.

The bit clock, frame sync and serial input are sampled by a faster system clock, and their edges are found in that clock domain. A frame begins at the bit-clock rising edge where frame sync is first seen high. The MSB of slot 0 is taken on the rising edge after that one. The six received words appear together, with a one-cycle strobe, once slot 5 is complete. Capture words are loaded through a parallel port at any time and take effect at the next frame boundary. A frame sync that arrives at the wrong bit count realigns the counter and sets a sticky error flag.

Top module: `tdm_slave_port`

## Requirements
- R1: After reset, rx_data_o, rx_valid_o, frame_err_o and sdout_o are all 0.
- R2: A frame starts at the bit-clock rising edge where fs_i is sampled high after being low. Slot 0 bit 31 is taken on the next rising edge. The following bits come MSB first, one per rising edge, and each slot is 32 bits wide.
- R3: Playback words for slots 0 to 5 appear together on rx_data_o, slot n at bits [32n+31:32n]. They come with a single-cycle rx_valid_o pulse once the last bit of slot 5 has been taken, exactly once per frame.
- R4: len_sel_i sets the valid length: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. Received bits below the valid length are ignored and read back as 0.
- R5: Capture words for slots 0 to 3 are sent MSB first, tx_data_i bits [32n+31:32n] in slot n. Bits below the valid length are sent as 0, and slots 4 to 7 are sent as 0.
- R6: sdout_o changes only after a bit-clock falling edge, with one exception. Slot 0 bit 31 is driven early, at the frame-start rising edge.
- R7: A tx_load_i pulse captures tx_data_i. The words are sent starting at the next frame start, and a load during a frame does not alter the frame being sent.
- R8: A frame start whose bit count differs from 256 realigns the bit counter and sets frame_err_o, which stays set until reset. The first frame start after reset sets no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | External bit clock |
| fs_i | input | 1 | External frame sync |
| sdin_i | input | 1 | Serial playback data |
| len_sel_i | input | 2 | Valid sample length select |
| tx_load_i | input | 1 | Load strobe for the capture words |
| tx_data_i | input | 128 | Four capture words, slot 0 in the low bits |
| sdout_o | output | 1 | Serial capture data |
| rx_data_o | output | 192 | Six playback words, slot 0 in the low bits |
| rx_valid_o | output | 1 | One-cycle strobe for new playback words |
| frame_err_o | output | 1 | Sticky framing error |

## Verification
Every length setting is tried with three data patterns. All-ones data shows exactly where the length mask cuts off. Random data, with the MSB of slot 0 forced on, exposes slot-order and bit-order mistakes and makes the early MSB visible. A per-slot pattern catches words that land in the wrong slot. Capture words are loaded in the middle of each frame, so every frame also checks that loads wait for the frame boundary. A short frame followed by a full one checks the error flag, that it stays set, and that the counter realigns.

// File: rtl/tdm_slave_pkg.sv
package tdm_slave_pkg;
  localparam int unsigned SLOT_W = 32;

  typedef enum logic [1:0] {
    LEN_16 = 2'd0,
    LEN_18 = 2'd1,
    LEN_20 = 2'd2,
    LEN_24 = 2'd3
  } len_sel_e;

  // keeps the top n bits of a slot
  function automatic logic [SLOT_W-1:0] len_mask(input logic [1:0] sel);
    int unsigned n;
    n = (sel == LEN_24) ? 24 : 16 + 2 * int'(sel);
    return ~({SLOT_W{1'b1}} >> n);
  endfunction
endpackage

// File: rtl/tdm_edge_det.sv
module tdm_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic fs_i,
  input  logic sdin_i,
  output logic rise_o,
  output logic fall_o,
  output logic fs_o,
  output logic sdin_o
);
  logic sclk_q, sclk_q2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      sclk_q2 <= 1'b0;
      fs_o    <= 1'b0;
      sdin_o  <= 1'b0;
    end else begin
      sclk_q  <= sclk_i;
      sclk_q2 <= sclk_q;
      fs_o    <= fs_i;
      sdin_o  <= sdin_i;
    end
  end

  assign rise_o = sclk_q & ~sclk_q2;
  assign fall_o = ~sclk_q & sclk_q2;
endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
  parameter int unsigned FRAME_BITS = 256,
  localparam int unsigned CNT_W = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fs_i,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic             frame_start_o,
  output logic             locked_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
  logic fs_prev;

  assign frame_start_o = rise_i & fs_i & ~fs_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_prev   <= 1'b0;
      bit_cnt_o <= '0;
      locked_o  <= 1'b0;
      err_o     <= 1'b0;
    end else if (rise_i) begin
      fs_prev <= fs_i;
      if (frame_start_o) begin
        bit_cnt_o <= '0;
        locked_o  <= 1'b1;
        if (locked_o && bit_cnt_o != LAST) err_o <= 1'b1;
      end else begin
        bit_cnt_o <= bit_cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned N_RX   = 6,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned BIT_W = $clog2(SLOT_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rise_i,
  input  logic                   locked_i,
  input  logic                   din_i,
  input  logic [CNT_W-1:0]       bit_cnt_i,
  input  logic [SLOT_W-1:0]      mask_i,
  output logic [N_RX*SLOT_W-1:0] data_o,
  output logic                   valid_o
);
  logic [SLOT_W-1:0]          sh, sh_nx;
  logic [(N_RX-1)*SLOT_W-1:0] stage;
  logic [CNT_W-BIT_W-1:0]     slot;
  logic                       word_done;

  assign slot      = bit_cnt_i[CNT_W-1:BIT_W];
  assign sh_nx     = {sh[SLOT_W-2:0], din_i};
  assign word_done = rise_i & locked_i & (&bit_cnt_i[BIT_W-1:0]) & (32'(slot) < N_RX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh      <= '0;
      stage   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) sh <= sh_nx;
      if (word_done) begin
        if (32'(slot) == N_RX - 1) begin
          data_o  <= {sh_nx & mask_i, stage};
          valid_o <= 1'b1;
        end else begin
          for (int i = 0; i < int'(N_RX) - 1; i++)
            if (32'(slot) == i) stage[i*SLOT_W +: SLOT_W] <= sh_nx & mask_i;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser #(
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned N_TX   = 4,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned BIT_W = $clog2(SLOT_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fall_i,
  input  logic                   fstart_i,
  input  logic                   locked_i,
  input  logic [CNT_W-1:0]       bit_cnt_i,
  input  logic [SLOT_W-1:0]      mask_i,
  input  logic                   load_i,
  input  logic [N_TX*SLOT_W-1:0] data_i,
  output logic                   sdout_o
);
  logic [N_TX*SLOT_W-1:0] pend, act;
  logic [CNT_W-BIT_W-1:0] slot;
  logic [BIT_W-1:0]       pos;
  logic                   nxt_bit;

  assign slot = bit_cnt_i[CNT_W-1:BIT_W];
  assign pos  = bit_cnt_i[BIT_W-1:0];

  always_comb begin
    nxt_bit = 1'b0;
    for (int i = 0; i < int'(N_TX); i++)
      if (32'(slot) == i)
        nxt_bit = act[i*SLOT_W + SLOT_W - 1 - int'(pos)] & mask_i[SLOT_W - 1 - int'(pos)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend    <= '0;
      act     <= '0;
      sdout_o <= 1'b0;
    end else begin
      if (load_i) pend <= data_i;
      if (fstart_i) begin
        act     <= pend;
        sdout_o <= pend[SLOT_W-1] & mask_i[SLOT_W-1];  // early slot 0 MSB
      end else if (fall_i && locked_i) begin
        sdout_o <= nxt_bit;
      end
    end
  end
endmodule

// File: rtl/tdm_slave_port.sv
module tdm_slave_port
  import tdm_slave_pkg::*;
#(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned N_RX    = 6,
  parameter int unsigned N_TX    = 4,
  localparam int unsigned FRAME_BITS = N_SLOTS * SLOT_W,
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   fs_i,
  input  logic                   sdin_i,
  input  logic [1:0]             len_sel_i,
  input  logic                   tx_load_i,
  input  logic [N_TX*SLOT_W-1:0] tx_data_i,
  output logic                   sdout_o,
  output logic [N_RX*SLOT_W-1:0] rx_data_o,
  output logic                   rx_valid_o,
  output logic                   frame_err_o
);
  logic             sclk_rise, sclk_fall, fs_s, din_s;
  logic [CNT_W-1:0] bit_cnt;
  logic             frame_start, locked;
  logic [SLOT_W-1:0] mask;

  assign mask = len_mask(len_sel_i);

  tdm_edge_det u_edge (
    .clk_i, .rst_ni, .sclk_i, .fs_i, .sdin_i,
    .rise_o(sclk_rise), .fall_o(sclk_fall), .fs_o(fs_s), .sdin_o(din_s)
  );

  tdm_frame_ctr #(.FRAME_BITS(FRAME_BITS)) u_ctr (
    .clk_i, .rst_ni, .rise_i(sclk_rise), .fs_i(fs_s),
    .bit_cnt_o(bit_cnt), .frame_start_o(frame_start), .locked_o(locked), .err_o(frame_err_o)
  );

  tdm_rx_deser #(.SLOT_W(SLOT_W), .N_RX(N_RX), .CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni, .rise_i(sclk_rise), .locked_i(locked), .din_i(din_s),
    .bit_cnt_i(bit_cnt), .mask_i(mask), .data_o(rx_data_o), .valid_o(rx_valid_o)
  );

  tdm_tx_ser #(.SLOT_W(SLOT_W), .N_TX(N_TX), .CNT_W(CNT_W)) u_tx (
    .clk_i, .rst_ni, .fall_i(sclk_fall), .fstart_i(frame_start), .locked_i(locked),
    .bit_cnt_i(bit_cnt), .mask_i(mask), .load_i(tx_load_i), .data_i(tx_data_i),
    .sdout_o
  );
endmodule

// File: rtl/tdm_slave_port_chk.sv
module tdm_slave_port_chk #(
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rise_i,
  input logic             fall_i,
  input logic             fstart_i,
  input logic             locked_i,
  input logic [CNT_W-1:0] bit_cnt_i,
  input logic             sdout_o,
  input logic             rx_valid_o,
  input logic [SLOT_W-25:0] rx_low_i,
  input logic             frame_err_o
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> frame_err_o);

  a_r8_misalign_sets_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fstart_i && locked_i && bit_cnt_i != LAST) |=> frame_err_o);

  a_r3_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r3_valid_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(rise_i));

  a_r6_sdout_moves_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdout_o) |-> $past(fall_i || fstart_i));

  a_r4_rx_tail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> rx_low_i == '0);
endmodule

bind tdm_slave_port tdm_slave_port_chk #(.SLOT_W(tdm_slave_pkg::SLOT_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(sclk_rise), .fall_i(sclk_fall),
  .fstart_i(frame_start), .locked_i(locked), .bit_cnt_i(bit_cnt),
  .sdout_o(sdout_o), .rx_valid_o(rx_valid_o),
  .rx_low_i(rx_data_o[tdm_slave_pkg::SLOT_W-25:0]), .frame_err_o(frame_err_o)
);

// File: tb/tdm_slave_port_tb.sv
module tdm_slave_port_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, fs = 1'b0, sdin = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic tx_load = 1'b0;
  logic [127:0] tx_data = '0;
  logic sdout, rx_valid, frame_err;
  logic [191:0] rx_data;

  always #4 clk = ~clk;

  tdm_slave_port u_dut (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .fs_i(fs), .sdin_i(sdin),
    .len_sel_i(len_sel), .tx_load_i(tx_load), .tx_data_i(tx_data),
    .sdout_o(sdout), .rx_data_o(rx_data), .rx_valid_o(rx_valid), .frame_err_o(frame_err)
  );

  int nvec = 0, nfail = 0, vcnt = 0;
  bit done = 0;
  logic [31:0] in_w[8], got_rx[6], got_tx[8];
  logic [31:0] tx_cur[4], tx_pend[4], tx_next[4];
  logic last_bit = 1'b0;
  logic early_seen;

  function automatic logic [31:0] bmask(input int sel);
    int n;
    n = (sel == 3) ? 24 : 16 + 2 * sel;
    return ~(32'hFFFF_FFFF >> n);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rx_valid) begin
      vcnt++;
      for (int i = 0; i < 6; i++) got_rx[i] = rx_data[i*32 +: 32];
    end

  task automatic run_frame(input int nbits, input bit chk_tx, input bit err_exp);
    int kk;
    for (int s = 0; s < 4; s++) tx_cur[s] = tx_pend[s];
    for (int s = 0; s < 8; s++) got_tx[s] = '0;
    vcnt = 0;
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      sclk = 1'b0;
      fs   = (k < nbits / 2);
      kk   = k - 1;
      sdin = (k == 0) ? last_bit : in_w[kk/32][31 - kk%32];
      if (k == 100) begin
        for (int s = 0; s < 4; s++) tx_data[s*32 +: 32] = tx_next[s];
        tx_load = 1'b1;
      end
      @(negedge clk);
      tx_load = 1'b0;
      repeat (3) @(negedge clk);
      if (k >= 1) got_tx[kk/32][31 - kk%32] = sdout;
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      if (k == 0) early_seen = sdout;
      @(negedge clk);
    end
    if (nbits >= 101) for (int s = 0; s < 4; s++) tx_pend[s] = tx_next[s];
    last_bit = in_w[(nbits-1)/32][31 - (nbits-1)%32];
    // R2/R3/R4: received words
    for (int s = 0; s < 6; s++)
      chk(got_rx[s] == (in_w[s] & bmask(len_sel)), s == 0 ? "R2 slot0 rx" : "R3/R4 rx word",
          got_rx[s], in_w[s] & bmask(len_sel));
    chk(vcnt == 1, "R3 one strobe per frame", 32'(vcnt), 32'd1);
    chk(early_seen == tx_cur[0][31], "R6 early MSB", 32'(early_seen), 32'(tx_cur[0][31]));
    if (chk_tx) begin
      for (int s = 0; s < 4; s++)
        chk(got_tx[s] == (tx_cur[s] & bmask(len_sel)), "R5/R7 tx word",
            got_tx[s], tx_cur[s] & bmask(len_sel));
      for (int s = 4; s < 7; s++)
        chk(got_tx[s] == '0, "R5 unused tx slot", got_tx[s], 32'd0);
    end
    chk(frame_err == err_exp, "R8 frame error", 32'(frame_err), 32'(err_exp));
  endtask

  task automatic setup(input int p);
    for (int s = 0; s < 8; s++) begin
      case (p)
        0: in_w[s] = 32'hFFFF_FFFF;
        1: in_w[s] = $urandom;
        default: in_w[s] = 32'hA5C3_5A3C ^ (32'(s) * 32'h0111_0111);
      endcase
    end
    for (int s = 0; s < 4; s++) begin
      case (p)
        0: tx_next[s] = 32'hFFFF_FFFF;
        1: tx_next[s] = $urandom | 32'h8000_0000;
        default: tx_next[s] = 32'h8E71_C3A5 ^ (32'(s) * 32'h1001_0010);
      endcase
    end
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin tx_pend[s] = '0; tx_next[s] = '0; end
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(rx_data == '0, "R1 rx_data reset", rx_data[31:0], 32'd0);
    chk(rx_valid == 1'b0, "R1 rx_valid reset", 32'(rx_valid), 32'd0);
    chk(frame_err == 1'b0, "R1 frame_err reset", 32'(frame_err), 32'd0);
    chk(sdout == 1'b0, "R1 sdout reset", 32'(sdout), 32'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 3; p++) begin
        len_sel = 2'(l);
        setup(p);
        run_frame(256, 1'b1, 1'b0);
      end
    // R8: short frame, then a full one after realignment
    setup(1);
    run_frame(200, 1'b0, 1'b0);
    setup(2);
    run_frame(256, 1'b1, 1'b1);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nvec++;
      nfail++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule